// File: doc/BRIEF.md
# Hot-Plug Slot Connection Sequencer

This block brings an expansion slot that can be plugged while the system runs from fully off to connected to the shared bus, in a fixed order. Software writes the control bits one step at a time: slot power, then slot reset, then slot clock, then the data-width request, and finally the bus isolation-switch enable. The sequencer only moves forward when the current step's control bit and preconditions hold. Its outputs are registered, so every slot-facing signal changes on a clock edge and all of them change together.

The block has two ways to close the bus switches. In manual mode software raises the bus-enable bit itself. In automatic mode the block closes the switches once the slot is clocked, power-good is present and the width request is set, and then a programmable number of settling cycles has elapsed. An attempt in manual mode to enable the switches before the earlier steps are complete has no effect and raises a sticky sequence-error flag. Clearing the power bit tears the slot down in one edge from any state.

Top module: `hp_slot_seq`

## Requirements
- R1: While and after reset, `seq_state` is 0 (OFF), `slot_pwr_on`=0, `slot_rst_act`=1, `slot_clk_en`=0, `bus_sw_en`=0, `slot_width32`=0 and `seq_err`=0.
- R2: In OFF with `ctl_pwr`=1 the state becomes POWERED (code 1) at the next edge. `slot_pwr_on` is 1 in every state except OFF.
- R3: POWERED moves to RESET (code 2) only at an edge where `pwr_good`=1 and `ctl_rst_n`=0. `slot_rst_act` is 1 in OFF, or when `ctl_rst_n` was 0 at the previous edge.
- R4: RESET moves to CLOCKED (code 3) at an edge where `ctl_clk_n`=0. `slot_clk_en` is 1 only in CLOCKED and CONNECTED (code 4). `ctl_clk_n`=1 in either of those states returns the state to RESET.
- R5: `slot_width32` is the value of `ctl_width32` at the previous edge (1 = 32-bit slot, 0 = 64-bit slot).
- R6: With `cfg_auto`=0, CLOCKED moves to CONNECTED at an edge where `ctl_bus_en`=1 and `ctl_req64_n`=0. CONNECTED returns to CLOCKED when `ctl_bus_en`=0. `bus_sw_en` is 1 only in CONNECTED.
- R7: With `cfg_auto`=1, CLOCKED moves to CONNECTED on the (`settle_cycles`+1)-th consecutive edge in CLOCKED with `pwr_good`=1 and `ctl_req64_n`=0. An edge without them restarts the count. `ctl_bus_en` has no effect in this mode.
- R8: With `cfg_auto`=0 and `ctl_pwr`=1, `ctl_bus_en`=1 in POWERED, in RESET, or in CLOCKED with `ctl_req64_n`=1 leaves the state unchanged and sets `seq_err`. `seq_err` stays set while `ctl_pwr`=1.
- R9: `ctl_pwr`=0 in any state gives OFF at the next edge. At that same edge `bus_sw_en` and `slot_clk_en` go 0, `slot_rst_act` goes 1 and `seq_err` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pwr | input | 1 | Software slot-power bit, 1 = power on |
| ctl_rst_n | input | 1 | Software reset bit, 0 = drive slot reset |
| ctl_clk_n | input | 1 | Software clock bit, 0 = clock the slot |
| ctl_req64_n | input | 1 | Width request bit, must be 0 before connecting |
| ctl_width32 | input | 1 | Slot width, 1 = 32-bit, 0 = 64-bit |
| ctl_bus_en | input | 1 | Manual bus-switch enable bit |
| cfg_auto | input | 1 | 1 = automatic switch enable |
| pwr_good | input | 1 | Slot supply within range |
| settle_cycles | input | CNT_W | Settling count for automatic mode |
| slot_pwr_on | output | 1 | Slot power enable |
| slot_rst_act | output | 1 | Slot reset, 1 = active |
| slot_clk_en | output | 1 | Slot clock enable |
| slot_width32 | output | 1 | Width indication to the card |
| bus_sw_en | output | 1 | Bus isolation-switch enable |
| seq_err | output | 1 | Sticky out-of-order enable flag |
| seq_state | output | 3 | Current state code 0..4 |

## Verification
A wrong internal state shows up on `seq_state` at the edge after the stimulus. The same edge also shows it on the derived enables: a stuck or skipped step gives a power, clock or switch enable that disagrees with the step code. A miscounted settling counter moves the rise of `bus_sw_en` one or more edges away from the (`settle_cycles`+1)-th edge, so the bench samples that output on every edge of the wait. A lost or leaked error bit shows on `seq_err` one edge after an early enable or after power is removed.

// File: rtl/hps_pkg.sv
package hps_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_POWERED   = 3'd1,
        ST_RESET     = 3'd2,
        ST_CLOCKED   = 3'd3,
        ST_CONNECTED = 3'd4
    } slot_state_e;

    typedef struct packed {
        slot_state_e state;
        logic        err;
    } fsm_reg_t;

    typedef struct packed {
        logic rst_req;
        logic w32;
    } drv_reg_t;

endpackage

// File: rtl/hps_settle_timer.sv
module hps_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run) begin
            cnt_d = (cnt_q == limit) ? cnt_q : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == limit);

    // R7: a break in the run condition restarts the settling count
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/hps_seq_fsm.sv
module hps_seq_fsm
    import hps_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_pwr,
    input  logic        ctl_rst_n,
    input  logic        ctl_clk_n,
    input  logic        ctl_req64_n,
    input  logic        ctl_bus_en,
    input  logic        cfg_auto,
    input  logic        pwr_good,
    input  logic        settle_done,
    output slot_state_e state,
    output logic        err,
    output logic        settle_run
);

    fsm_reg_t fsm_d, fsm_q;
    logic     width_ok;
    logic     early;

    assign width_ok = !ctl_req64_n;

    always_comb begin
        early = !cfg_auto && ctl_bus_en &&
                ((fsm_q.state == ST_POWERED) || (fsm_q.state == ST_RESET) ||
                 ((fsm_q.state == ST_CLOCKED) && !width_ok));

        fsm_d     = fsm_q;
        fsm_d.err = fsm_q.err | early;

        unique case (fsm_q.state)
            ST_OFF: begin
                if (ctl_pwr) fsm_d.state = ST_POWERED;
            end
            ST_POWERED: begin
                if (pwr_good && !ctl_rst_n) fsm_d.state = ST_RESET;
            end
            ST_RESET: begin
                if (!ctl_clk_n) fsm_d.state = ST_CLOCKED;
            end
            ST_CLOCKED: begin
                if (ctl_clk_n)
                    fsm_d.state = ST_RESET;
                else if (cfg_auto ? settle_done : (ctl_bus_en && width_ok))
                    fsm_d.state = ST_CONNECTED;
            end
            ST_CONNECTED: begin
                if (ctl_clk_n)
                    fsm_d.state = ST_RESET;
                else if (!cfg_auto && !ctl_bus_en)
                    fsm_d.state = ST_CLOCKED;
            end
            default: fsm_d.state = ST_OFF;
        endcase

        if (!ctl_pwr) begin
            fsm_d.state = ST_OFF;
            fsm_d.err   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{state: ST_OFF, err: 1'b0};
        else        fsm_q <= fsm_d;
    end

    assign state      = fsm_q.state;
    assign err        = fsm_q.err;
    assign settle_run = ctl_pwr && cfg_auto && pwr_good && width_ok &&
                        !ctl_clk_n && (fsm_q.state == ST_CLOCKED);

    // R9: removing power always lands in OFF with the error cleared
    a_r9_power_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_pwr |=> (fsm_q.state == ST_OFF) && !fsm_q.err);

    // R3: reset step is never taken without power-good
    a_r3_needs_pg: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_POWERED) && !pwr_good |=> fsm_q.state != ST_RESET);

    // R8: an early manual enable raises the error flag
    a_r8_early_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_pwr && !cfg_auto && ctl_bus_en &&
        ((fsm_q.state == ST_POWERED) || (fsm_q.state == ST_RESET)) |=> fsm_q.err);

    // R8: the error flag is sticky while power stays requested
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_pwr && fsm_q.err |=> fsm_q.err);

endmodule

// File: rtl/hps_slot_drive.sv
module hps_slot_drive
    import hps_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  slot_state_e state,
    input  logic        ctl_rst_n,
    input  logic        ctl_width32,
    output logic        slot_pwr_on,
    output logic        slot_rst_act,
    output logic        slot_clk_en,
    output logic        slot_width32,
    output logic        bus_sw_en
);

    drv_reg_t drv_d, drv_q;

    always_comb begin
        drv_d.rst_req = !ctl_rst_n;
        drv_d.w32     = ctl_width32;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_q <= '{rst_req: 1'b1, w32: 1'b0};
        else        drv_q <= drv_d;
    end

    assign slot_pwr_on  = (state != ST_OFF);
    assign slot_rst_act = (state == ST_OFF) || drv_q.rst_req;
    assign slot_clk_en  = (state == ST_CLOCKED) || (state == ST_CONNECTED);
    assign bus_sw_en    = (state == ST_CONNECTED);
    assign slot_width32 = drv_q.w32;

    // R5: width indication follows the software bit one edge later
    a_r5_width_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> slot_width32 == $past(ctl_width32));

endmodule

// File: rtl/hp_slot_seq.sv
module hp_slot_seq
    import hps_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_pwr,
    input  logic             ctl_rst_n,
    input  logic             ctl_clk_n,
    input  logic             ctl_req64_n,
    input  logic             ctl_width32,
    input  logic             ctl_bus_en,
    input  logic             cfg_auto,
    input  logic             pwr_good,
    input  logic [CNT_W-1:0] settle_cycles,
    output logic             slot_pwr_on,
    output logic             slot_rst_act,
    output logic             slot_clk_en,
    output logic             slot_width32,
    output logic             bus_sw_en,
    output logic             seq_err,
    output logic [2:0]       seq_state
);

    slot_state_e state;
    logic        settle_run;
    logic        settle_done;

    hps_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (settle_run),
        .limit (settle_cycles),
        .done  (settle_done)
    );

    hps_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_pwr     (ctl_pwr),
        .ctl_rst_n   (ctl_rst_n),
        .ctl_clk_n   (ctl_clk_n),
        .ctl_req64_n (ctl_req64_n),
        .ctl_bus_en  (ctl_bus_en),
        .cfg_auto    (cfg_auto),
        .pwr_good    (pwr_good),
        .settle_done (settle_done),
        .state       (state),
        .err         (seq_err),
        .settle_run  (settle_run)
    );

    hps_slot_drive u_drive (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (state),
        .ctl_rst_n    (ctl_rst_n),
        .ctl_width32  (ctl_width32),
        .slot_pwr_on  (slot_pwr_on),
        .slot_rst_act (slot_rst_act),
        .slot_clk_en  (slot_clk_en),
        .slot_width32 (slot_width32),
        .bus_sw_en    (bus_sw_en)
    );

    assign seq_state = state;

    // R6: switches only ever close from the clocked step
    a_r6_from_clocked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_sw_en) |-> $past(seq_state) == 3'd3);

    // R7: in automatic mode a switch closure needs power-good
    a_r7_auto_pg: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_auto && $past(cfg_auto) && $rose(bus_sw_en) |-> $past(pwr_good));

    // R9: teardown of every slot signal on one edge
    a_r9_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != 3'd0) && !ctl_pwr |=>
        !bus_sw_en && !slot_clk_en && slot_rst_act && !slot_pwr_on);

endmodule

// File: tb/test_hp_slot_seq.sv
module test_hp_slot_seq;

    localparam int CNT_W = 8;
    localparam int NVEC  = 16;
    // bits: [11]pwr [10]rst_n [9]clk_n [8]req64_n [7]w32 [6]bus_en [5]auto [4]pg [3:1]state [0]err
    localparam logic [11:0] VEC [NVEC] = '{
        12'b0111_0000_0000, 12'b1111_0000_0010, 12'b1011_0000_0010, 12'b1111_0100_0011,
        12'b0111_0000_0000, 12'b1111_0000_0010, 12'b1011_0001_0100, 12'b1001_0001_0110,
        12'b1001_0101_0111, 12'b1000_0001_0111, 12'b1000_1101_1001, 12'b1100_1101_1001,
        12'b1100_1001_0111, 12'b1100_1101_1001, 12'b1110_1101_0101, 12'b0110_1101_0000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_pwr = 0, ctl_rst_n = 1, ctl_clk_n = 1, ctl_req64_n = 1;
    logic ctl_width32 = 0, ctl_bus_en = 0, cfg_auto = 0, pwr_good = 0;
    logic [CNT_W-1:0] settle_cycles = '0;
    logic slot_pwr_on, slot_rst_act, slot_clk_en, slot_width32, bus_sw_en, seq_err;
    logic [2:0] seq_state;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;

    always #10 clk = ~clk;

    hp_slot_seq #(.CNT_W(CNT_W)) i_hp_slot_seq (
        .clk(clk), .rst_n(rst_n), .ctl_pwr(ctl_pwr), .ctl_rst_n(ctl_rst_n),
        .ctl_clk_n(ctl_clk_n), .ctl_req64_n(ctl_req64_n), .ctl_width32(ctl_width32),
        .ctl_bus_en(ctl_bus_en), .cfg_auto(cfg_auto), .pwr_good(pwr_good),
        .settle_cycles(settle_cycles), .slot_pwr_on(slot_pwr_on),
        .slot_rst_act(slot_rst_act), .slot_clk_en(slot_clk_en),
        .slot_width32(slot_width32), .bus_sw_en(bus_sw_en), .seq_err(seq_err),
        .seq_state(seq_state)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    // expected outputs computed from the requirements for a given state code
    task automatic check_all(input logic [2:0] st, input bit rstn_in, input bit w32_in,
                             input bit err, input string req);
        check(seq_state == st, {req, " state"}, seq_state, st);
        check(slot_pwr_on == (st != 3'd0), "R2 power", slot_pwr_on, st != 3'd0);
        check(slot_rst_act == ((st == 3'd0) || !rstn_in), "R3 reset", slot_rst_act,
              (st == 3'd0) || !rstn_in);
        check(slot_clk_en == (st == 3'd3 || st == 3'd4), "R4 clock", slot_clk_en,
              st == 3'd3 || st == 3'd4);
        check(bus_sw_en == (st == 3'd4), "R6 switch", bus_sw_en, st == 3'd4);
        check(slot_width32 == w32_in, "R5 width", slot_width32, w32_in);
        check(seq_err == err, "R8 error", seq_err, err);
    endtask

    function automatic string tag_of(input logic [2:0] st);
        case (st)
            3'd0:    return "R9";
            3'd1:    return "R2";
            3'd2:    return "R3";
            3'd3:    return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic go_clocked();
        ctl_pwr = 1; pwr_good = 1; ctl_rst_n = 0; ctl_clk_n = 0;
        ctl_req64_n = 0; cfg_auto = 1;
        tick(); tick(); tick();
        check(seq_state == 3'd3, "R7 reach clocked", seq_state, 3);
    endtask

    task automatic power_down();
        ctl_pwr = 0;
        tick();
        check_all(3'd0, ctl_rst_n, ctl_width32, 1'b0, "R9");
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #5;
        check_all(3'd0, 1'b1, 1'b0, 1'b0, "R1");
        rst_n = 1;
        tick();
        check_all(3'd0, 1'b1, 1'b0, 1'b0, "R1");

        // table walk, manual mode
        for (int i = 0; i < NVEC; i++) begin
            ctl_pwr     = VEC[i][11];
            ctl_rst_n   = VEC[i][10];
            ctl_clk_n   = VEC[i][9];
            ctl_req64_n = VEC[i][8];
            ctl_width32 = VEC[i][7];
            ctl_bus_en  = VEC[i][6];
            cfg_auto    = VEC[i][5];
            pwr_good    = VEC[i][4];
            tick();
            check_all(VEC[i][3:1], VEC[i][10], VEC[i][7], VEC[i][0], tag_of(VEC[i][3:1]));
        end

        // R7: automatic mode, settle 3, bus enable ignored and no error
        ctl_bus_en = 1; settle_cycles = 8'd3;
        go_clocked();
        for (int k = 0; k < 3; k++) begin
            tick();
            check(bus_sw_en == 1'b0, "R7 settle wait", bus_sw_en, 0);
        end
        tick();
        check(bus_sw_en == 1'b1, "R7 settle done", bus_sw_en, 1);
        check(seq_err == 1'b0, "R7 bus_en ignored", seq_err, 0);
        // R9: teardown from connected
        power_down();

        // R7: settle 0 connects on the first edge
        settle_cycles = 8'd0; ctl_bus_en = 0;
        go_clocked();
        tick();
        check(seq_state == 3'd4, "R7 zero settle", seq_state, 4);
        power_down();

        // R7: power-good loss restarts the count
        settle_cycles = 8'd2;
        go_clocked();
        tick(); tick();
        check(bus_sw_en == 1'b0, "R7 partial count", bus_sw_en, 0);
        pwr_good = 0;
        tick();
        check(seq_state == 3'd3, "R7 pg drop holds", seq_state, 3);
        pwr_good = 1;
        tick(); tick();
        check(bus_sw_en == 1'b0, "R7 restarted count", bus_sw_en, 0);
        tick();
        check(bus_sw_en == 1'b1, "R7 connect after restart", bus_sw_en, 1);
        power_down();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule